// File: doc/BRIEF.md
# Bus Machine-State Sequencer

This block is the clock-state controller of a small 8-bit processor whose low address byte and data share one set of pins. It steps each machine cycle through its states: an address state, a strobe state, any number of ready-wait states, a data state, and up to three internal states. Between cycles it can park in a halt state or a hold state, and it sits in a reset state while reset is held. Every state change happens on the falling clock edge. The rest of the processor describes each coming cycle with a descriptor: a kind, a length in states and a bus-idle flag. The sequencer captures that descriptor on the edge that enters the cycle's first state. It then drives the status code, the memory/IO select, the address-latch enable, the active-low read, write and interrupt-acknowledge strobes, and the output enables for the upper address lines, the shared low lines and the control strobes.

The decode logic upstream watches `desc_load`, which is high while the coming falling edge will start a new cycle, and it presents the next descriptor before that edge. An external hold requester gets `hlda`. The sequencer then releases the pins after a configurable number of hold states.

Top module: `msq_top`

## Requirements
- R1: `t_state` reports the state with the codes T1=0, T2=1, TWAIT=2, T3=3, T4=4, T5=5, T6=6, TRESET=7, THALT=8, THOLD=9. State changes occur only on falling clock edges. T1 is always followed by T2.
- R2: In T2 and in TWAIT, `ready` is sampled on the falling edge. When it is low the next state is TWAIT, and when it is high the next state is T3.
- R3: A cycle whose length field is 3 or less ends after T3. Length 4 ends after T4, length 5 after T5, and length 6 or 7 after T6.
- R4: `ale` is high only in T1 of a cycle whose bus-idle flag is clear. In every other state, and in every state of a bus-idle cycle, it is low.
- R5: The kind codes are fetch=0, memory read=1, memory write=2, IO read=3, IO write=4, interrupt acknowledge=5, restart=6. In T2, TWAIT and T3 of a non-idle cycle, `rd_n` is low for kinds 0, 1 and 3, `wr_n` is low for kinds 2 and 4, and `inta_n` is low for kind 5. All three strobes are high at every other time, and for kind 6.
- R6: During T1 to T6, `io_m` is 1 for kinds 3, 4 and 5 in every state. For kind 6 it is 1 in T4 to T6 and 0 in T1 to T3. For kinds 0, 1 and 2 it is 0.
- R7: During T1 to T6, `st` is 2'b11 for kinds 0, 5 and 6, 2'b10 for kinds 1 and 3, and 2'b01 for kinds 2 and 4. In TRESET, THALT and THOLD it is 2'b00.
- R8: While `rst` is high, each falling edge puts the block in TRESET. In TRESET all strobes are high, `ale` is low, and `hi_oe` and `lo_oe` are low. The first falling edge after `rst` is released enters T1.
- R9: At the end of a cycle, with `hold_req` low and `halt_req` high and `vint` low, the block enters THALT, where `hi_oe` and `lo_oe` are low. It stays in THALT until a falling edge sees `vint` high, which enters T1. If `halt_req` and `vint` are both high at the end of the cycle, the block goes straight to T1.
- R10: At the end of a cycle, `hold_req` takes priority over `halt_req` and enters THOLD, and `hlda` is high exactly while in THOLD. `hi_oe`, `lo_oe` and `ctl_oe` stay high for HOLD_LAG states after entry, then go low. When `hold_req` is low at a falling edge in THOLD, the block enters T1 with `hlda` low and `ctl_oe` high.
- R11: `desc_load` is high exactly when the coming falling edge enters T1. The descriptor inputs captured at that edge govern the whole cycle, even if the inputs change during the cycle.
- R12: `lo_oe` is high in T1 of a non-idle cycle and in T2, TWAIT and T3 of a non-idle write cycle (kinds 2 and 4), and low in every other state of a cycle. `hi_oe` is high in every state T1 to T6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the state register moves on its falling edge |
| rst | input | 1 | Synchronous active-high reset, sampled on the falling edge |
| cyc_kind | input | 3 | Kind of the next machine cycle |
| cyc_len | input | 3 | Length of the next machine cycle in states |
| cyc_idle | input | 1 | Next cycle does not use the bus |
| ready | input | 1 | Memory or IO ready, sampled in T2 and TWAIT |
| hold_req | input | 1 | External request for the bus |
| halt_req | input | 1 | Halt after the current cycle |
| vint | input | 1 | A pending interrupt that is enabled and unmasked |
| t_state | output | 4 | Current state code |
| desc_load | output | 1 | Next falling edge captures the descriptor and enters T1 |
| hlda | output | 1 | Hold acknowledge |
| st | output | 2 | Cycle status code |
| io_m | output | 1 | 1 selects IO, 0 selects memory |
| ale | output | 1 | Address-latch enable |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |
| inta_n | output | 1 | Interrupt-acknowledge strobe, active low |
| hi_oe | output | 1 | Drive enable for the upper address lines |
| lo_oe | output | 1 | Drive enable for the shared low address/data lines |
| ctl_oe | output | 1 | Drive enable for the read and write strobes |

## Verification
The bench builds the block with its default HOLD_LAG of 1. With that value, the one THOLD state that still drives the pins can be seen by itself between the edge that raises `hlda` and the edge that releases the pins. The 3-bit length field lets the bench use the out-of-range lengths 2 and 7 next to 4, 5 and 6, so both ends of the length clipping are checked. Wait-state insertion, halt exit with and without a simultaneous interrupt, hold priority over halt, and a reset that lands in the middle of a cycle are each driven as a separate directed scenario.

// File: rtl/msq_pkg.sv
package msq_pkg;

    localparam int KIND_W = 3;
    localparam int LEN_W  = 3;
    localparam int ST_W   = 4;

    typedef enum logic [ST_W-1:0] {
        TS_T1    = 4'd0,
        TS_T2    = 4'd1,
        TS_TW    = 4'd2,
        TS_T3    = 4'd3,
        TS_T4    = 4'd4,
        TS_T5    = 4'd5,
        TS_T6    = 4'd6,
        TS_RESET = 4'd7,
        TS_HALT  = 4'd8,
        TS_HOLD  = 4'd9
    } tstate_e;

    typedef enum logic [KIND_W-1:0] {
        K_FETCH = 3'd0,
        K_MRD   = 3'd1,
        K_MWR   = 3'd2,
        K_IORD  = 3'd3,
        K_IOWR  = 3'd4,
        K_INTA  = 3'd5,
        K_RSTV  = 3'd6,
        K_SPARE = 3'd7
    } kind_e;

    typedef struct packed {
        kind_e            kind;
        logic [LEN_W-1:0] len;
        logic             idle;
    } desc_t;

    typedef struct packed {
        logic [1:0] st;
        logic       io_m;
        logic       ale;
        logic       rd_n;
        logic       wr_n;
        logic       inta_n;
        logic       hi_oe;
        logic       lo_oe;
        logic       ctl_oe;
    } bus_ctl_t;

    // cycle kinds that pulse the read strobe
    function automatic logic kind_reads(kind_e k);
        return (k == K_FETCH) || (k == K_MRD) || (k == K_IORD);
    endfunction

    // cycle kinds that pulse the write strobe and drive data
    function automatic logic kind_writes(kind_e k);
        return (k == K_MWR) || (k == K_IOWR);
    endfunction

    // cycle kinds that select IO space for the whole cycle
    function automatic logic kind_io(kind_e k);
        return (k == K_IORD) || (k == K_IOWR) || (k == K_INTA);
    endfunction

    function automatic logic [1:0] kind_status(kind_e k);
        logic [1:0] s;
        case (k)
            K_FETCH, K_INTA, K_RSTV: s = 2'b11;
            K_MRD, K_IORD:           s = 2'b10;
            K_MWR, K_IOWR:           s = 2'b01;
            default:                 s = 2'b00;
        endcase
        return s;
    endfunction

    // state after which a cycle of the given length finishes
    function automatic tstate_e final_state(logic [LEN_W-1:0] len);
        tstate_e s;
        if (int'(len) <= 3)       s = TS_T3;
        else if (int'(len) == 4)  s = TS_T4;
        else if (int'(len) == 5)  s = TS_T5;
        else                      s = TS_T6;
        return s;
    endfunction

    function automatic logic in_cycle(tstate_e s);
        return (s == TS_T1) || (s == TS_T2) || (s == TS_TW) || (s == TS_T3) ||
               (s == TS_T4) || (s == TS_T5) || (s == TS_T6);
    endfunction

    function automatic logic in_strobe(tstate_e s);
        return (s == TS_T2) || (s == TS_TW) || (s == TS_T3);
    endfunction

    function automatic logic in_tail(tstate_e s);
        return (s == TS_T4) || (s == TS_T5) || (s == TS_T6);
    endfunction

endpackage

// File: rtl/msq_fsm.sv
module msq_fsm
    import msq_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  desc_t   desc_in,
    input  logic    ready,
    input  logic    hold_req,
    input  logic    halt_req,
    input  logic    vint,
    output tstate_e state,
    output desc_t   desc_q,
    output logic    hlda,
    output logic    desc_load
);

    tstate_e nxt;
    tstate_e end_nxt;
    logic    at_last;

    always_comb begin
        // decision taken when the current cycle runs out
        if (hold_req)
            end_nxt = TS_HOLD;
        else if (halt_req && !vint)
            end_nxt = TS_HALT;
        else
            end_nxt = TS_T1;

        at_last = (state == final_state(desc_q.len));

        case (state)
            TS_RESET: nxt = TS_T1;
            TS_T1:    nxt = TS_T2;
            TS_T2,
            TS_TW:    nxt = ready ? TS_T3 : TS_TW;
            TS_T3:    nxt = at_last ? end_nxt : TS_T4;
            TS_T4:    nxt = at_last ? end_nxt : TS_T5;
            TS_T5:    nxt = at_last ? end_nxt : TS_T6;
            TS_T6:    nxt = end_nxt;
            TS_HALT:  nxt = vint ? TS_T1 : TS_HALT;
            TS_HOLD:  nxt = hold_req ? TS_HOLD : TS_T1;
            default:  nxt = TS_RESET;
        endcase

        if (rst)
            nxt = TS_RESET;

        desc_load = (nxt == TS_T1);
    end

    always_ff @(negedge clk) begin
        if (rst) begin
            state  <= TS_RESET;
            hlda   <= 1'b0;
            desc_q <= desc_t'('0);
        end else begin
            state <= nxt;
            hlda  <= (nxt == TS_HOLD);
            if (desc_load)
                desc_q <= desc_in;
        end
    end

endmodule

// File: rtl/msq_holdoff.sv
module msq_holdoff #(
    parameter int HOLD_LAG = 1
) (
    input  logic clk,
    input  logic rst,
    input  logic hlda,
    output logic bus_off
);

    generate
        if (HOLD_LAG == 0) begin : g_direct
            assign bus_off = hlda;
        end else begin : g_chain
            logic [HOLD_LAG-1:0] sh;
            for (genvar i = 0; i < HOLD_LAG; i++) begin : g_stage
                always_ff @(negedge clk) begin
                    if (rst)
                        sh[i] <= 1'b0;
                    else if (i == 0)
                        sh[i] <= hlda;
                    else
                        sh[i] <= hlda & sh[(i == 0) ? 0 : i-1];
                end
            end
            // released together with hlda, asserted HOLD_LAG edges later
            assign bus_off = sh[HOLD_LAG-1] & hlda;
        end
    endgenerate

endmodule

// File: rtl/msq_busctl.sv
module msq_busctl
    import msq_pkg::*;
(
    input  tstate_e  state,
    input  desc_t    desc,
    input  logic     bus_off,
    output bus_ctl_t ctl
);

    logic strobe_on;

    always_comb begin
        strobe_on  = in_strobe(state) && !desc.idle;

        ctl        = '0;
        ctl.rd_n   = 1'b1;
        ctl.wr_n   = 1'b1;
        ctl.inta_n = 1'b1;
        ctl.ctl_oe = !bus_off;

        if (in_cycle(state)) begin
            ctl.st    = kind_status(desc.kind);
            ctl.hi_oe = 1'b1;
            ctl.ale   = (state == TS_T1) && !desc.idle;
            ctl.lo_oe = !desc.idle &&
                        ((state == TS_T1) || (in_strobe(state) && kind_writes(desc.kind)));
            ctl.io_m  = kind_io(desc.kind) ||
                        ((desc.kind == K_RSTV) && in_tail(state));
            if (strobe_on) begin
                ctl.rd_n   = !kind_reads(desc.kind);
                ctl.wr_n   = !kind_writes(desc.kind);
                ctl.inta_n = !(desc.kind == K_INTA);
            end
        end else if (state == TS_HOLD) begin
            ctl.hi_oe = !bus_off;
            ctl.lo_oe = !bus_off;
        end
    end

endmodule

// File: rtl/msq_top.sv
module msq_top
    import msq_pkg::*;
#(
    parameter int HOLD_LAG = 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [KIND_W-1:0] cyc_kind,
    input  logic [LEN_W-1:0]  cyc_len,
    input  logic              cyc_idle,
    input  logic              ready,
    input  logic              hold_req,
    input  logic              halt_req,
    input  logic              vint,
    output logic [ST_W-1:0]   t_state,
    output logic              desc_load,
    output logic              hlda,
    output logic [1:0]        st,
    output logic              io_m,
    output logic              ale,
    output logic              rd_n,
    output logic              wr_n,
    output logic              inta_n,
    output logic              hi_oe,
    output logic              lo_oe,
    output logic              ctl_oe
);

    desc_t    desc_in;
    desc_t    cur_desc;
    tstate_e  state;
    logic     bus_off;
    bus_ctl_t ctl;

    assign desc_in = '{kind: kind_e'(cyc_kind), len: cyc_len, idle: cyc_idle};

    msq_fsm u_fsm (
        .clk       (clk),
        .rst       (rst),
        .desc_in   (desc_in),
        .ready     (ready),
        .hold_req  (hold_req),
        .halt_req  (halt_req),
        .vint      (vint),
        .state     (state),
        .desc_q    (cur_desc),
        .hlda      (hlda),
        .desc_load (desc_load)
    );

    msq_holdoff #(.HOLD_LAG(HOLD_LAG)) u_holdoff (
        .clk     (clk),
        .rst     (rst),
        .hlda    (hlda),
        .bus_off (bus_off)
    );

    msq_busctl u_busctl (
        .state   (state),
        .desc    (cur_desc),
        .bus_off (bus_off),
        .ctl     (ctl)
    );

    assign t_state = state;
    assign st      = ctl.st;
    assign io_m    = ctl.io_m;
    assign ale     = ctl.ale;
    assign rd_n    = ctl.rd_n;
    assign wr_n    = ctl.wr_n;
    assign inta_n  = ctl.inta_n;
    assign hi_oe   = ctl.hi_oe;
    assign lo_oe   = ctl.lo_oe;
    assign ctl_oe  = ctl.ctl_oe;

endmodule

// File: rtl/msq_chk.sv
module msq_chk #(
    parameter int HOLD_LAG = 1
) (
    input logic       clk,
    input logic       rst,
    input logic [3:0] t_state,
    input logic [2:0] kind,
    input logic       ready,
    input logic       vint,
    input logic       hlda,
    input logic       ale,
    input logic       rd_n,
    input logic       wr_n,
    input logic       inta_n,
    input logic       io_m,
    input logic       hi_oe,
    input logic       lo_oe,
    input logic       ctl_oe
);

    AST_T1_LEADS_T2: assert property (@(negedge clk) disable iff (rst)
        (t_state == 4'd0) |=> (t_state == 4'd1)); // R1

    AST_WAIT_ON_LOW_READY: assert property (@(negedge clk) disable iff (rst)
        ((t_state == 4'd1 || t_state == 4'd2) && !ready) |=> (t_state == 4'd2)); // R2

    AST_T3_ON_READY: assert property (@(negedge clk) disable iff (rst)
        ((t_state == 4'd1 || t_state == 4'd2) && ready) |=> (t_state == 4'd3)); // R2

    AST_ALE_T1_ONLY: assert property (@(negedge clk) disable iff (rst)
        ale |-> (t_state == 4'd0)); // R4

    AST_ONE_STROBE: assert property (@(negedge clk) disable iff (rst)
        $countones({~rd_n, ~wr_n, ~inta_n}) <= 1); // R5

    AST_IOM_ACK_TAIL: assert property (@(negedge clk) disable iff (rst)
        ((t_state >= 4'd4 && t_state <= 4'd6) && (kind == 3'd5 || kind == 3'd6)) |-> io_m); // R6

    AST_RESET_QUIET: assert property (@(negedge clk) disable iff (rst)
        (t_state == 4'd7) |-> (rd_n && wr_n && inta_n && !ale && !hi_oe && !lo_oe)); // R8

    AST_HALT_STAYS: assert property (@(negedge clk) disable iff (rst)
        ((t_state == 4'd8) && !vint) |=> (t_state == 4'd8)); // R9

    AST_HLDA_IN_HOLD: assert property (@(negedge clk) disable iff (rst)
        (t_state == 4'd9) |-> hlda); // R10

    AST_OFF_NEEDS_HLDA: assert property (@(negedge clk) disable iff (rst)
        !ctl_oe |-> hlda); // R10

    generate
        if (HOLD_LAG > 0) begin : g_lag
            AST_BUS_OFF_LATE: assert property (@(negedge clk) disable iff (rst)
                $rose(hlda) |-> ctl_oe); // R10
        end
    endgenerate

endmodule

bind msq_top msq_chk #(.HOLD_LAG(HOLD_LAG)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .t_state (t_state),
    .kind    (cur_desc.kind),
    .ready   (ready),
    .vint    (vint),
    .hlda    (hlda),
    .ale     (ale),
    .rd_n    (rd_n),
    .wr_n    (wr_n),
    .inta_n  (inta_n),
    .io_m    (io_m),
    .hi_oe   (hi_oe),
    .lo_oe   (lo_oe),
    .ctl_oe  (ctl_oe)
);

// File: tb/tb_msq_top.sv
`timescale 1ns/1ps
module tb_msq_top;

    localparam int S_T1 = 0, S_T2 = 1, S_TW = 2, S_T3 = 3, S_T4 = 4, S_T5 = 5, S_T6 = 6;
    localparam int S_RESET = 7, S_HALT = 8, S_HOLD = 9;
    localparam int KF = 0, KMR = 1, KMW = 2, KIR = 3, KIW = 4, KIA = 5, KRS = 6;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [2:0] cyc_kind = 3'd1;
    logic [2:0] cyc_len = 3'd3;
    logic       cyc_idle = 1'b0;
    logic       ready = 1'b1;
    logic       hold_req = 1'b0;
    logic       halt_req = 1'b0;
    logic       vint = 1'b0;
    logic [3:0] t_state;
    logic       desc_load, hlda, io_m, ale, rd_n, wr_n, inta_n, hi_oe, lo_oe, ctl_oe;
    logic [1:0] st;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2 clk = ~clk;

    msq_top dut (
        .clk(clk), .rst(rst), .cyc_kind(cyc_kind), .cyc_len(cyc_len), .cyc_idle(cyc_idle),
        .ready(ready), .hold_req(hold_req), .halt_req(halt_req), .vint(vint),
        .t_state(t_state), .desc_load(desc_load), .hlda(hlda), .st(st), .io_m(io_m),
        .ale(ale), .rd_n(rd_n), .wr_n(wr_n), .inta_n(inta_n), .hi_oe(hi_oe),
        .lo_oe(lo_oe), .ctl_oe(ctl_oe)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // outputs settle at the falling edge; sample at the rising edge
    task automatic nxt();
        @(posedge clk);
    endtask

    task automatic set_desc(input int k, input int l, input bit idle);
        cyc_kind = 3'(k);
        cyc_len  = 3'(l);
        cyc_idle = idle;
    endtask

    task automatic t_reset();
        rst = 1'b1;
        set_desc(KMR, 3, 0);
        repeat (3) nxt();
        chk("R8", "state", t_state, S_RESET);
        chk("R8", "strobes", {rd_n, wr_n, inta_n}, 7);
        chk("R8", "ale", ale, 0);
        chk("R8", "hi_oe", hi_oe, 0);
        chk("R8", "lo_oe", lo_oe, 0);
        chk("R7", "st", st, 0);
        chk("R11", "load in reset", desc_load, 0);
        rst = 1'b0;
    endtask

    task automatic t_read3();
        set_desc(KMR, 3, 0);
        nxt();
        chk("R8", "first T1", t_state, S_T1);
        chk("R4", "ale T1", ale, 1);
        chk("R12", "lo_oe T1", lo_oe, 1);
        chk("R12", "hi_oe T1", hi_oe, 1);
        chk("R5", "rd_n T1", rd_n, 1);
        chk("R7", "st read", st, 2);
        chk("R6", "io_m mem", io_m, 0);
        chk("R11", "load T1", desc_load, 0);
        set_desc(KMW, 6, 1);  // changed mid-cycle, must not take effect
        nxt();
        chk("R1", "T2", t_state, S_T2);
        chk("R5", "rd_n T2", rd_n, 0);
        chk("R4", "ale T2", ale, 0);
        chk("R12", "lo_oe read T2", lo_oe, 0);
        nxt();
        chk("R2", "T3", t_state, S_T3);
        chk("R11", "captured kind kept", {rd_n, wr_n}, 1);
        chk("R11", "load last", desc_load, 1);
    endtask

    task automatic t_write4_wait();
        set_desc(KMW, 4, 0);
        nxt();
        chk("R7", "st write", st, 1);
        chk("R12", "lo_oe T1", lo_oe, 1);
        nxt();
        chk("R5", "wr_n T2", wr_n, 0);
        chk("R5", "rd_n T2 write", rd_n, 1);
        chk("R12", "lo_oe write T2", lo_oe, 1);
        chk("R11", "load T2", desc_load, 0);
        ready = 1'b0;
        nxt();
        chk("R2", "TWAIT", t_state, S_TW);
        chk("R5", "wr_n TWAIT", wr_n, 0);
        nxt();
        chk("R2", "TWAIT again", t_state, S_TW);
        ready = 1'b1;
        nxt();
        chk("R2", "T3 after wait", t_state, S_T3);
        nxt();
        chk("R3", "T4 len4", t_state, S_T4);
        chk("R5", "wr_n T4", wr_n, 1);
        chk("R12", "lo_oe T4", lo_oe, 0);
        chk("R11", "load T4", desc_load, 1);
    endtask

    task automatic t_inta6();
        set_desc(KIA, 6, 0);
        nxt();
        chk("R6", "io_m ack T1", io_m, 1);
        chk("R7", "st ack", st, 3);
        nxt();
        chk("R5", "inta_n T2", inta_n, 0);
        chk("R5", "rd_n ack", rd_n, 1);
        nxt();
        nxt();
        chk("R3", "T4 len6", t_state, S_T4);
        chk("R6", "io_m ack T4", io_m, 1);
        chk("R5", "inta_n T4", inta_n, 1);
        nxt();
        nxt();
        chk("R3", "T6 len6", t_state, S_T6);
        chk("R6", "io_m ack T6", io_m, 1);
        chk("R11", "load T6", desc_load, 1);
    endtask

    task automatic t_restart5();
        set_desc(KRS, 5, 0);
        nxt();
        chk("R6", "io_m restart T1", io_m, 0);
        chk("R7", "st restart", st, 3);
        nxt();
        chk("R6", "io_m restart T2", io_m, 0);
        chk("R5", "no strobe restart", {rd_n, wr_n, inta_n}, 7);
        nxt();
        nxt();
        chk("R6", "io_m restart T4", io_m, 1);
        nxt();
        chk("R3", "T5 len5", t_state, S_T5);
        chk("R6", "io_m restart T5", io_m, 1);
        chk("R11", "load T5", desc_load, 1);
    endtask

    task automatic t_idle7();
        set_desc(KMR, 7, 1);
        nxt();
        chk("R4", "ale idle", ale, 0);
        chk("R12", "lo_oe idle", lo_oe, 0);
        chk("R12", "hi_oe idle", hi_oe, 1);
        nxt();
        chk("R5", "rd_n idle", rd_n, 1);
        repeat (4) nxt();
        chk("R3", "T6 len7", t_state, S_T6);
        chk("R11", "load len7", desc_load, 1);
    endtask

    task automatic t_ioread2();
        set_desc(KIR, 2, 0);
        nxt();
        chk("R6", "io_m io read", io_m, 1);
        chk("R7", "st io read", st, 2);
        nxt();
        chk("R5", "rd_n io", rd_n, 0);
        nxt();
        chk("R3", "T3 len2", t_state, S_T3);
        chk("R3", "len2 ends", desc_load, 1);
    endtask

    task automatic t_halt();
        set_desc(KMR, 3, 0);
        halt_req = 1'b1;
        nxt();
        chk("R9", "enter halt", t_state, S_HALT);
        chk("R7", "st halt", st, 0);
        chk("R9", "oe halt", {hi_oe, lo_oe}, 0);
        chk("R5", "strobes halt", {rd_n, wr_n, inta_n}, 7);
        halt_req = 1'b0;
        nxt();
        nxt();
        chk("R9", "stay halt", t_state, S_HALT);
        chk("R11", "no load halt", desc_load, 0);
        vint = 1'b1;
        nxt();
        chk("R9", "leave halt", t_state, S_T1);
        vint = 1'b0;
        nxt();
        nxt();
    endtask

    task automatic t_halt_vint();
        set_desc(KMR, 3, 0);
        halt_req = 1'b1;
        vint = 1'b1;
        nxt();
        chk("R9", "halt with vint", t_state, S_T1);
        halt_req = 1'b0;
        vint = 1'b0;
        nxt();
        nxt();
    endtask

    task automatic t_hold();
        set_desc(KMR, 3, 0);
        hold_req = 1'b1;
        nxt();
        chk("R10", "enter hold", t_state, S_HOLD);
        chk("R10", "hlda", hlda, 1);
        chk("R10", "ctl_oe lag", ctl_oe, 1);
        chk("R10", "hi_oe lag", hi_oe, 1);
        nxt();
        chk("R10", "ctl_oe off", ctl_oe, 0);
        chk("R10", "bus off", {hi_oe, lo_oe}, 0);
        chk("R7", "st hold", st, 0);
        nxt();
        chk("R10", "stay hold", t_state, S_HOLD);
        hold_req = 1'b0;
        nxt();
        chk("R10", "leave hold", t_state, S_T1);
        chk("R10", "hlda drop", hlda, 0);
        chk("R10", "ctl_oe back", ctl_oe, 1);
        chk("R4", "ale after hold", ale, 1);
        nxt();
        nxt();
    endtask

    task automatic t_hold_over_halt();
        set_desc(KMR, 3, 0);
        hold_req = 1'b1;
        halt_req = 1'b1;
        nxt();
        chk("R10", "hold wins", t_state, S_HOLD);
        hold_req = 1'b0;
        halt_req = 1'b0;
        nxt();
        chk("R10", "resume", t_state, S_T1);
        nxt();
        nxt();
    endtask

    task automatic t_reset_mid();
        set_desc(KMR, 3, 0);
        nxt();
        nxt();
        chk("R5", "rd_n before reset", rd_n, 0);
        rst = 1'b1;
        nxt();
        chk("R8", "mid reset", t_state, S_RESET);
        chk("R8", "rd_n reset", rd_n, 1);
        chk("R8", "hi_oe reset", hi_oe, 0);
        rst = 1'b0;
        nxt();
        chk("R8", "T1 after release", t_state, S_T1);
        nxt();
        nxt();
        chk("R1", "T3 after restart", t_state, S_T3);
    endtask

    initial begin
        t_reset();
        t_read3();
        t_write4_wait();
        t_inta6();
        t_restart5();
        t_idle7();
        t_ioread2();
        t_halt();
        t_halt_vint();
        t_hold();
        t_hold_over_halt();
        t_reset_mid();
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule